// File: doc/BRIEF.md
# Exception Mask Register Unit

This block holds the interrupt-masking state of a processor core. There are two single-bit masks, a primary mask and a fault mask, and an unsigned base-priority threshold. An instruction stage presents decoded requests to the block. A change-state request sets or clears either mask or both. A register write names one target register. A register read names one source and returns its value on the read port in the same cycle.

Every update requires the privilege input to be high. The block also provides a "raise-only" alias for the base-priority register: a write through the alias is accepted only when it tightens the masking threshold. The mask outputs and the base-priority output go straight to the interrupt controller. The application status flags live outside this block. Writes that name them are accepted by that other logic and have no effect here.

Top module: `excmask_regs`

## Requirements
- R1: While reset is asserted, and after it is released, the primary mask, the fault mask and the base priority are all zero.
- R2: A privileged change-state request with `cps_dis_i`=1 sets every mask it selects, and with `cps_dis_i`=0 clears them. `cps_pm_i` selects the primary mask and `cps_fm_i` selects the fault mask. Either one, both or none may be selected, and a mask that is not selected keeps its value.
- R3: A change-state request with `priv_i`=0 leaves all three registers unchanged.
- R4: A register write with `priv_i`=0 leaves all three registers unchanged, whatever the selector.
- R5: A privileged write loads the selected register. Selector 1 loads the primary mask and selector 2 loads the fault mask, each from `wr_data_i[0]`. Selector 3 loads base priority from `wr_data_i[7:0]` with no condition, zero included. Selectors 0 and 5 to 7 change nothing.
- R6: A privileged write with selector 4, the raise-only alias, loads `wr_data_i[7:0]` into base priority only when that value is nonzero and the current value is either zero or greater than it. Otherwise base priority keeps its value.
- R7: `rd_data_o` is combinational and zero-extended. Selector 1 reads the primary mask in bit 0, selector 2 reads the fault mask in bit 0, selectors 3 and 4 both read base priority in bits 7:0, and every other selector reads zero. A read in the same cycle as a write returns the old value.
- R8: A register write presented in the same cycle as a change-state request is discarded, whether or not the change-state request itself takes effect.
- R9: Register outputs change only on the clock edge that follows the request. Before that edge they still show the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| priv_i | input | 1 | 1 = privileged execution |
| cps_vld_i | input | 1 | Change-state request valid |
| cps_dis_i | input | 1 | 1 = set the selected masks, 0 = clear them |
| cps_pm_i | input | 1 | Change-state request selects the primary mask |
| cps_fm_i | input | 1 | Change-state request selects the fault mask |
| wr_vld_i | input | 1 | Register write valid |
| wr_sel_i | input | 3 | Write target selector |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 3 | Read source selector |
| rd_data_o | output | 32 | Read data, zero-extended |
| pmask_o | output | 1 | Primary mask |
| fmask_o | output | 1 | Fault mask |
| bpri_o | output | 8 | Base-priority threshold |

## Verification
The hardest state to reach from the ports is the raise-only alias write. Its outcome depends on the pair formed by the stored threshold and the new value, and that pair includes the zero-threshold case and values on either side of the stored one. The stimulus first loads a chosen threshold through the unconditional selector. It then issues an alias write with a new value, and repeats this for 16 thresholds spread over the range, each paired with all 256 new values, with junk placed in the upper data bits. Collisions between change-state requests and writes are swept across both privilege levels and every combination of mask selection.

// File: rtl/excmask_pkg.sv
package excmask_pkg;

  typedef enum logic [2:0] {
    SEL_FLAGS    = 3'd0,
    SEL_PMASK    = 3'd1,
    SEL_FMASK    = 3'd2,
    SEL_BPRI     = 3'd3,
    SEL_BPRI_MAX = 3'd4
  } sreg_sel_e;

  localparam int unsigned MIDX_PRIM  = 0;
  localparam int unsigned MIDX_FAULT = 1;
  localparam int unsigned NUM_MASKS  = 2;

endpackage

// File: rtl/excmask_cps_dec.sv
module excmask_cps_dec #(
  parameter int unsigned NMASK = 2
) (
  input  logic             apply_i,
  input  logic             set_i,
  input  logic [NMASK-1:0] sel_i,
  input  logic [NMASK-1:0] cur_i,
  output logic [NMASK-1:0] nxt_o,
  output logic [NMASK-1:0] en_o
);

  for (genvar g = 0; g < NMASK; g++) begin : g_bit
    always_comb begin
      en_o[g]  = apply_i & sel_i[g];
      nxt_o[g] = en_o[g] ? set_i : cur_i[g];
    end
  end

endmodule

// File: rtl/excmask_bpri_gate.sv
module excmask_bpri_gate #(
  parameter int unsigned PRI_W = 8
) (
  input  logic [PRI_W-1:0] cur_i,
  input  logic [PRI_W-1:0] new_i,
  output logic             raise_ok_o
);

  logic new_nz;
  logic cur_zero;
  logic tighter;

  always_comb begin
    new_nz     = |new_i;
    cur_zero   = (cur_i == '0);
    tighter    = (new_i < cur_i);
    raise_ok_o = new_nz & (cur_zero | tighter);
  end

endmodule

// File: rtl/excmask_rdmux.sv
module excmask_rdmux
  import excmask_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRI_W  = 8
) (
  input  logic [2:0]        sel_i,
  input  logic              pmask_i,
  input  logic              fmask_i,
  input  logic [PRI_W-1:0]  bpri_i,
  output logic [DATA_W-1:0] data_o
);

  sreg_sel_e sel;

  always_comb begin
    sel    = sreg_sel_e'(sel_i);
    data_o = '0;
    case (sel)
      SEL_PMASK:              data_o[0] = pmask_i;
      SEL_FMASK:              data_o[0] = fmask_i;
      SEL_BPRI, SEL_BPRI_MAX: data_o[PRI_W-1:0] = bpri_i;
      default:                data_o = '0;
    endcase
  end

endmodule

// File: rtl/excmask_regs.sv
module excmask_regs
  import excmask_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRI_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv_i,
  input  logic              cps_vld_i,
  input  logic              cps_dis_i,
  input  logic              cps_pm_i,
  input  logic              cps_fm_i,
  input  logic              wr_vld_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pmask_o,
  output logic              fmask_o,
  output logic [PRI_W-1:0]  bpri_o
);

  localparam int unsigned NMASK = NUM_MASKS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // state
  logic [NMASK-1:0] mask_q, mask_nxt, mask_en;
  logic [PRI_W-1:0] bpri_q, bpri_nxt;
  logic             bpri_en;

  // change-state decode
  logic [NMASK-1:0] cps_sel, cps_nxt, cps_en;

  always_comb begin
    cps_sel             = '0;
    cps_sel[MIDX_PRIM]  = cps_pm_i;
    cps_sel[MIDX_FAULT] = cps_fm_i;
  end

  excmask_cps_dec #(.NMASK(NMASK)) u_cps_dec (
    .apply_i (cps_vld_i & priv_i),
    .set_i   (cps_dis_i),
    .sel_i   (cps_sel),
    .cur_i   (mask_q),
    .nxt_o   (cps_nxt),
    .en_o    (cps_en)
  );

  // raise-only qualification
  logic raise_ok;

  excmask_bpri_gate #(.PRI_W(PRI_W)) u_bpri_gate (
    .cur_i      (bpri_q),
    .new_i      (wr_data_i[PRI_W-1:0]),
    .raise_ok_o (raise_ok)
  );

  // next state
  sreg_sel_e wsel;
  logic      wr_ok;

  always_comb begin
    wsel     = sreg_sel_e'(wr_sel_i);
    wr_ok    = wr_vld_i & priv_i & ~cps_vld_i;
    mask_nxt = mask_q;
    mask_en  = '0;
    bpri_nxt = bpri_q;
    bpri_en  = 1'b0;
    if (cps_vld_i) begin
      mask_nxt = cps_nxt;
      mask_en  = cps_en;
    end else if (wr_ok) begin
      case (wsel)
        SEL_PMASK: begin
          mask_nxt[MIDX_PRIM] = wr_data_i[0];
          mask_en[MIDX_PRIM]  = 1'b1;
        end
        SEL_FMASK: begin
          mask_nxt[MIDX_FAULT] = wr_data_i[0];
          mask_en[MIDX_FAULT]  = 1'b1;
        end
        SEL_BPRI: begin
          bpri_nxt = wr_data_i[PRI_W-1:0];
          bpri_en  = 1'b1;
        end
        SEL_BPRI_MAX: begin
          bpri_nxt = wr_data_i[PRI_W-1:0];
          bpri_en  = raise_ok;
        end
        default: begin
          bpri_en = 1'b0;
        end
      endcase
    end
  end

  // registers
  for (genvar g = 0; g < NMASK; g++) begin : g_mask
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n)     mask_q[g] <= 1'b0;
      else if (mask_en[g]) mask_q[g] <= mask_nxt[g];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   bpri_q <= '0;
    else if (bpri_en) bpri_q <= bpri_nxt;
  end

  assign pmask_o = mask_q[MIDX_PRIM];
  assign fmask_o = mask_q[MIDX_FAULT];
  assign bpri_o  = bpri_q;

  excmask_rdmux #(.DATA_W(DATA_W), .PRI_W(PRI_W)) u_rdmux (
    .sel_i   (rd_sel_i),
    .pmask_i (mask_q[MIDX_PRIM]),
    .fmask_i (mask_q[MIDX_FAULT]),
    .bpri_i  (bpri_q),
    .data_o  (rd_data_o)
  );

  // assertions
  AST_UNPRIV_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !priv_i |=> ($stable(pmask_o) && $stable(fmask_o) && $stable(bpri_o))); // R3

  AST_CPS_SETS_PRIM: assert property (@(posedge clk) disable iff (!rst_int_n)
    (priv_i && cps_vld_i && cps_dis_i && cps_pm_i) |=> pmask_o); // R2

  AST_BPRI_RAISE_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_vld_i && !cps_vld_i && wr_sel_i == 3'(SEL_BPRI_MAX))
    |=> ($stable(bpri_o) ||
         (bpri_o != '0 && ($past(bpri_o) == '0 || bpri_o < $past(bpri_o))))); // R6

  AST_CPS_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cps_vld_i && wr_vld_i && wr_sel_i == 3'(SEL_BPRI)) |=> $stable(bpri_o)); // R8

  AST_ALIAS_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_sel_i == 3'(SEL_BPRI_MAX)) |-> (rd_data_o == DATA_W'(bpri_o))); // R7

endmodule

// File: tb/excmask_regs_bench.sv
module excmask_regs_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        priv_i, cps_vld_i, cps_dis_i, cps_pm_i, cps_fm_i, wr_vld_i;
  logic [2:0]  wr_sel_i, rd_sel_i;
  logic [31:0] wr_data_i, rd_data_o;
  logic        pmask_o, fmask_o;
  logic [7:0]  bpri_o;

  int n_cmp = 0;
  int n_bad = 0;

  // model
  bit       m_pm, m_fm;
  bit [7:0] m_bp;

  always #(CLK_PERIOD/2) clk = ~clk;

  excmask_regs u_excmask_regs (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .cps_vld_i(cps_vld_i),
    .cps_dis_i(cps_dis_i), .cps_pm_i(cps_pm_i), .cps_fm_i(cps_fm_i),
    .wr_vld_i(wr_vld_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .pmask_o(pmask_o),
    .fmask_o(fmask_o), .bpri_o(bpri_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] s);
    case (s)
      3'd1: exp_rd = {31'd0, m_pm};
      3'd2: exp_rd = {31'd0, m_fm};
      3'd3, 3'd4: exp_rd = {24'd0, m_bp};
      default: exp_rd = 32'd0;
    endcase
  endfunction

  task automatic idle();
    priv_i = 1'b0; cps_vld_i = 1'b0; cps_dis_i = 1'b0; cps_pm_i = 1'b0;
    cps_fm_i = 1'b0; wr_vld_i = 1'b0; wr_sel_i = 3'd0; wr_data_i = 32'd0;
    rd_sel_i = 3'd0;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit pv, input bit cv, input bit cd, input bit cp,
                      input bit cf, input bit wv, input logic [2:0] ws,
                      input logic [31:0] wd, input logic [2:0] rs, input string req);
    priv_i = pv; cps_vld_i = cv; cps_dis_i = cd; cps_pm_i = cp; cps_fm_i = cf;
    wr_vld_i = wv; wr_sel_i = ws; wr_data_i = wd; rd_sel_i = rs;
    #1;
    chk("R7 read old value", rd_data_o, exp_rd(rs));
    chk("R9 pre-edge hold", {22'd0, pmask_o, fmask_o, bpri_o}, {22'd0, m_pm, m_fm, m_bp});
    if (cv) begin
      if (pv) begin
        if (cp) m_pm = cd;
        if (cf) m_fm = cd;
      end
    end else if (wv && pv) begin
      case (ws)
        3'd1: m_pm = wd[0];
        3'd2: m_fm = wd[0];
        3'd3: m_bp = wd[7:0];
        3'd4: if (wd[7:0] != 8'd0 && (m_bp == 8'd0 || wd[7:0] < m_bp)) m_bp = wd[7:0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk({req, " pmask"}, {31'd0, pmask_o}, {31'd0, m_pm});
    chk({req, " fmask"}, {31'd0, fmask_o}, {31'd0, m_fm});
    chk({req, " bpri"},  {24'd0, bpri_o},  {24'd0, m_bp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    m_pm = 1'b0; m_fm = 1'b0; m_bp = 8'd0;
    #1;
    chk("R1 reset pmask", {31'd0, pmask_o}, 32'd0);
    chk("R1 reset fmask", {31'd0, fmask_o}, 32'd0);
    chk("R1 reset bpri",  {24'd0, bpri_o},  32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {22'd0, pmask_o, fmask_o, bpri_o}, 32'd0);
  endtask

  function automatic logic [31:0] pat(input int k);
    case (k % 6)
      0: pat = 32'h0000_0000;
      1: pat = 32'hFFFF_FFFF;
      2: pat = 32'hA5A5_5A01;
      3: pat = 32'h1234_5680;
      4: pat = 32'h0000_0001;
      default: pat = 32'hDEAD_BE7E;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R2 / R3: change-state over both privileges, all selections, all start states
    for (int st = 0; st < 4; st++)
      for (int pv = 0; pv < 2; pv++)
        for (int cd = 0; cd < 2; cd++)
          for (int sel = 0; sel < 4; sel++) begin
            step(1, 0, 0, 0, 0, 1, 3'd1, 32'(st & 1), 3'd1, "R5 prep");
            step(1, 0, 0, 0, 0, 1, 3'd2, 32'(st >> 1), 3'd2, "R5 prep");
            step(pv[0], 1, cd[0], sel[0], sel[1], 0, 3'd0, 32'd0, 3'(1 + (sel & 1)),
                 pv ? "R2 change-state" : "R3 unprivileged change-state");
          end

    // R4: unprivileged writes, every selector
    step(1, 0, 0, 0, 0, 1, 3'd3, 32'h40, 3'd3, "R5 prep");
    step(1, 1, 1, 1, 1, 0, 3'd0, 32'd0, 3'd0, "R2 prep");
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 6; k++)
        step(0, 0, 0, 0, 0, 1, 3'(s), pat(k), 3'(s), "R4 unprivileged write");

    // R5: privileged plain writes, every selector
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 6; k++)
        step(1, 0, 0, 0, 0, 1, 3'(s), pat(k + s), 3'((s + k) % 8), "R5 privileged write");

    // R6: raise-only alias sweep
    for (int cur = 0; cur < 256; cur += 17)
      for (int nv = 0; nv < 256; nv++) begin
        step(1, 0, 0, 0, 0, 1, 3'd3, 32'(cur), 3'd4, "R5 prep");
        step(1, 0, 0, 0, 0, 1, 3'd4, {24'hC3A500 >> (nv % 3), 8'(nv)} , 3'd4,
             "R6 alias write");
      end

    // R8: collisions between change-state and writes
    for (int pv = 0; pv < 2; pv++)
      for (int sel = 0; sel < 4; sel++)
        for (int s = 1; s < 5; s++) begin
          step(1, 0, 0, 0, 0, 1, 3'd3, 32'h20, 3'd3, "R5 prep");
          step(pv[0], 1, sel[0], sel[0], sel[1], 1, 3'(s), 32'h0000_0011, 3'(s),
               "R8 change-state beats write");
        end

    // R1: reset after activity
    step(1, 1, 1, 1, 1, 0, 3'd0, 32'd0, 3'd0, "R2 prep");
    step(1, 0, 0, 0, 0, 1, 3'd3, 32'h99, 3'd3, "R5 prep");
    do_reset();

    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule